// File: doc/BRIEF.md
# UART Clock Source Selector

This block decides where a UART's receiver and transmitter get their timing from, and turns that timing into the sample strobes the serial shifters consume. It accepts a one-cycle tick from an internal baud-rate generator, plus three asynchronous pins that can carry clocks: a dedicated receive-clock pin, the data-set-ready input and the ring-indicator input. The pins are synchronised and reduced to one-cycle enables on their rising edges. An 8-bit configuration byte selects the source for each direction and chooses between isochronous 1x sampling and OVERSAMPLE-times (default 16x) sampling for each.

In oversampled mode a per-direction prescaler passes on every OVERSAMPLE-th enable. The receiver prescaler can be realigned by the start-edge detector so that its strobes land in mid-bit. The same byte also chooses what drives the data-terminal-ready output: the ordinary modem-control level, the transmitter's bit strobe, or the raw baud-generator tick. A channel reset clears the prescalers but leaves the configuration byte unchanged. Only a hardware reset clears that byte.

Top module: `uart_clk_sel`

## Requirements
- R1: After hardware reset (rst_ni low) the configuration byte reads 0x00, both iso flags are 0, and one cycle later dtr_pin_o follows modem_dtr_i.
- R2: A write (cfg_we_i high at a clock edge) stores cfg_wdata_i into the configuration byte from the next cycle on, except bit 2, which always reads 0.
- R3: chan_rst_i high at a clock edge restarts both prescalers from count zero and leaves the configuration byte unchanged.
- R4: Bits [1:0] pick the receiver enable: 0 = rx_clk_pin_i rising edge, 1 = dsr_pin_i rising edge, 2 = brg_tick_i, 3 = the transmitter's selected enable.
- R5: Bit 3 set makes rx_iso_o 1 and makes rx_sample_o pulse in the same cycle as every selected receiver enable.
- R6: Bit 3 clear makes rx_sample_o pulse on every OVERSAMPLE-th receiver enable after the prescaler is cleared. After rx_start_i is high for a cycle, the next pulse comes on the (OVERSAMPLE/2)-th receiver enable.
- R7: Bit 6 picks the transmitter enable: 0 = brg_tick_i, 1 = ri_pin_i rising edge.
- R8: Bit 7 set makes tx_iso_o 1 and tx_bit_o pulse with every transmitter enable. Bit 7 clear gives a pulse on every OVERSAMPLE-th transmitter enable.
- R9: dtr_pin_o is registered one cycle after its source. Bits [5:4] = 0 or 3 select modem_dtr_i, 1 selects tx_bit_o, and 2 selects brg_tick_i.
- R10: A rising edge on an external clock pin gives exactly one enable cycle, SYNC_STAGES cycles after the first clock edge that sees the pin high. No enable is produced while the pin stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous hardware reset |
| chan_rst_i | input | 1 | Synchronous channel reset (prescalers only) |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_wdata_i | input | 8 | Configuration write data |
| cfg_rdata_o | output | 8 | Configuration byte readback |
| brg_tick_i | input | 1 | Internal baud generator tick, one cycle |
| rx_clk_pin_i | input | 1 | Asynchronous external receive clock |
| dsr_pin_i | input | 1 | Asynchronous data-set-ready pin |
| ri_pin_i | input | 1 | Asynchronous ring-indicator pin |
| rx_start_i | input | 1 | Start edge seen by receiver, realigns rx prescaler |
| modem_dtr_i | input | 1 | Normal data-terminal-ready level |
| rx_sample_o | output | 1 | Receiver sample strobe |
| tx_bit_o | output | 1 | Transmitter bit strobe |
| rx_iso_o | output | 1 | Receiver in 1x mode |
| tx_iso_o | output | 1 | Transmitter in 1x mode |
| dtr_pin_o | output | 1 | Data-terminal-ready output |

## Verification
The bench builds the block with OVERSAMPLE = 8 and SYNC_STAGES = 2. With these values a full prescaler wrap needs only eight ticks, so the wrap point, the mid-bit realignment after four ticks, and two consecutive wraps all fit in short directed runs. Two synchroniser stages give a fixed latency that the bench checks cycle by cycle. Every receiver source is driven with every stimulus kind, which shows that each unselected input produces no strobe.

// File: rtl/uart_clk_sel_pkg.sv
package uart_clk_sel_pkg;

  typedef enum logic [1:0] {
    RX_SRC_PIN = 2'd0,
    RX_SRC_DSR = 2'd1,
    RX_SRC_BRG = 2'd2,
    RX_SRC_TX  = 2'd3
  } rx_src_e;

  typedef enum logic [1:0] {
    DTR_MODEM  = 2'd0,
    DTR_TX_BIT = 2'd1,
    DTR_BRG    = 2'd2,
    DTR_RSVD   = 2'd3
  } dtr_mode_e;

  // field layout is software-visible
  typedef struct packed {
    logic      tx_iso;
    logic      tx_ext;
    dtr_mode_e dtr_mode;
    logic      rx_iso;
    logic      rsvd;
    rx_src_e   rx_src;
  } clk_cfg_t;

  localparam int unsigned NUM_EXT_CLK = 3;
  localparam int unsigned EXT_RXCLK   = 0;
  localparam int unsigned EXT_DSR     = 1;
  localparam int unsigned EXT_RI      = 2;

endpackage

// File: rtl/clk_edge_sync.sv
module clk_edge_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pin_i,
  output logic rise_o
);

  logic [STAGES:0] chain_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) chain_q <= '0;
    else         chain_q <= {chain_q[STAGES-1:0], pin_i};
  end

  // last stage is only used as the edge-detect history
  assign rise_o = chain_q[STAGES-1] & ~chain_q[STAGES];

endmodule

// File: rtl/bit_prescaler.sv
module bit_prescaler #(
  parameter int unsigned OVS = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic en_i,
  input  logic iso_i,
  input  logic realign_i,
  output logic strobe_o
);

  localparam int unsigned CW = (OVS > 2) ? $clog2(OVS) : 1;
  localparam logic [CW-1:0] LAST = CW'(OVS - 1);
  localparam logic [CW-1:0] HALF = CW'(OVS / 2);

  logic [CW-1:0] cnt_q;
  logic          wrap;

  assign wrap     = (cnt_q == LAST);
  assign strobe_o = en_i & (iso_i | wrap);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (clr_i) begin
      cnt_q <= '0;
    end else if (realign_i) begin
      cnt_q <= HALF;
    end else if (en_i && !iso_i) begin
      cnt_q <= wrap ? '0 : cnt_q + 1'b1;
    end
  end

endmodule

// File: rtl/uart_clk_sel.sv
module uart_clk_sel #(
  parameter int unsigned OVERSAMPLE  = 16,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       chan_rst_i,
  input  logic       cfg_we_i,
  input  logic [7:0] cfg_wdata_i,
  output logic [7:0] cfg_rdata_o,
  input  logic       brg_tick_i,
  input  logic       rx_clk_pin_i,
  input  logic       dsr_pin_i,
  input  logic       ri_pin_i,
  input  logic       rx_start_i,
  input  logic       modem_dtr_i,
  output logic       rx_sample_o,
  output logic       tx_bit_o,
  output logic       rx_iso_o,
  output logic       tx_iso_o,
  output logic       dtr_pin_o
);

  import uart_clk_sel_pkg::*;

  localparam logic [7:0] WR_MASK = 8'hFB;

  clk_cfg_t cfg_q;
  logic [NUM_EXT_CLK-1:0] pins, pin_rise;
  logic tx_en, rx_en, dtr_d, dtr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       cfg_q <= '0;
    else if (cfg_we_i) cfg_q <= clk_cfg_t'(cfg_wdata_i & WR_MASK);
  end

  assign cfg_rdata_o = cfg_q;
  assign rx_iso_o    = cfg_q.rx_iso;
  assign tx_iso_o    = cfg_q.tx_iso;

  assign pins[EXT_RXCLK] = rx_clk_pin_i;
  assign pins[EXT_DSR]   = dsr_pin_i;
  assign pins[EXT_RI]    = ri_pin_i;

  for (genvar g = 0; g < NUM_EXT_CLK; g++) begin : g_sync
    clk_edge_sync #(.STAGES(SYNC_STAGES)) i_sync (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .pin_i  (pins[g]),
      .rise_o (pin_rise[g])
    );
  end

  assign tx_en = cfg_q.tx_ext ? pin_rise[EXT_RI] : brg_tick_i;

  always_comb begin
    unique case (cfg_q.rx_src)
      RX_SRC_PIN: rx_en = pin_rise[EXT_RXCLK];
      RX_SRC_DSR: rx_en = pin_rise[EXT_DSR];
      RX_SRC_BRG: rx_en = brg_tick_i;
      default:    rx_en = tx_en;
    endcase
  end

  bit_prescaler #(.OVS(OVERSAMPLE)) i_rx_pre (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clr_i     (chan_rst_i),
    .en_i      (rx_en),
    .iso_i     (cfg_q.rx_iso),
    .realign_i (rx_start_i),
    .strobe_o  (rx_sample_o)
  );

  bit_prescaler #(.OVS(OVERSAMPLE)) i_tx_pre (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clr_i     (chan_rst_i),
    .en_i      (tx_en),
    .iso_i     (cfg_q.tx_iso),
    .realign_i (1'b0),
    .strobe_o  (tx_bit_o)
  );

  always_comb begin
    unique case (cfg_q.dtr_mode)
      DTR_TX_BIT: dtr_d = tx_bit_o;
      DTR_BRG:    dtr_d = brg_tick_i;
      default:    dtr_d = modem_dtr_i;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) dtr_q <= 1'b0;
    else         dtr_q <= dtr_d;
  end

  assign dtr_pin_o = dtr_q;

endmodule

// File: rtl/uart_clk_sel_chk.sv
module uart_clk_sel_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       chan_rst_i,
  input logic       cfg_we_i,
  input logic [7:0] cfg_wdata_i,
  input logic [7:0] cfg_rdata_o,
  input logic       brg_tick_i,
  input logic       modem_dtr_i,
  input logic       rx_sample_o,
  input logic       tx_bit_o,
  input logic       rx_iso_o,
  input logic       tx_iso_o,
  input logic       dtr_pin_o
);

  p_rsvd_zero_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_rdata_o[2] == 1'b0);

  p_write_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_we_i |=> cfg_rdata_o == ($past(cfg_wdata_i) & 8'hFB));

  p_chan_rst_keep_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (chan_rst_i && !cfg_we_i) |=> $stable(cfg_rdata_o));

  p_rx_iso_brg_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_iso_o && cfg_rdata_o[1:0] == 2'b10) |-> rx_sample_o == brg_tick_i);

  p_rx_nx_needs_tick_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!rx_iso_o && cfg_rdata_o[1:0] == 2'b10 && rx_sample_o) |-> brg_tick_i);

  p_tx_iso_brg_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_iso_o && !cfg_rdata_o[6]) |-> tx_bit_o == brg_tick_i);

  p_dtr_modem_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_rdata_o[5:4] == 2'b00 || cfg_rdata_o[5:4] == 2'b11)
      |=> dtr_pin_o == $past(modem_dtr_i));

  p_dtr_brg_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_rdata_o[5:4] == 2'b10) |=> dtr_pin_o == $past(brg_tick_i));

endmodule

bind uart_clk_sel uart_clk_sel_chk i_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .chan_rst_i  (chan_rst_i),
  .cfg_we_i    (cfg_we_i),
  .cfg_wdata_i (cfg_wdata_i),
  .cfg_rdata_o (cfg_rdata_o),
  .brg_tick_i  (brg_tick_i),
  .modem_dtr_i (modem_dtr_i),
  .rx_sample_o (rx_sample_o),
  .tx_bit_o    (tx_bit_o),
  .rx_iso_o    (rx_iso_o),
  .tx_iso_o    (tx_iso_o),
  .dtr_pin_o   (dtr_pin_o)
);

// File: tb/test_uart_clk_sel.sv
`timescale 1ns/1ps
module test_uart_clk_sel;

  localparam int OVS = 8;

  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       chan_rst = 1'b0, cfg_we = 1'b0;
  logic [7:0] cfg_wdata = '0, cfg_rdata;
  logic       brg = 1'b0, rxp = 1'b0, dsr = 1'b0, ri = 1'b0, start = 1'b0;
  logic       modem = 1'b0;
  logic       rx_s, tx_b, rx_iso, tx_iso, dtr;

  int checks = 0, fails = 0;
  int n_rx = 0, n_tx = 0;

  always #5 clk = ~clk;

  uart_clk_sel #(.OVERSAMPLE(OVS), .SYNC_STAGES(2)) i_uart_clk_sel (
    .clk_i(clk), .rst_ni(rst_ni), .chan_rst_i(chan_rst),
    .cfg_we_i(cfg_we), .cfg_wdata_i(cfg_wdata), .cfg_rdata_o(cfg_rdata),
    .brg_tick_i(brg), .rx_clk_pin_i(rxp), .dsr_pin_i(dsr), .ri_pin_i(ri),
    .rx_start_i(start), .modem_dtr_i(modem),
    .rx_sample_o(rx_s), .tx_bit_o(tx_b), .rx_iso_o(rx_iso),
    .tx_iso_o(tx_iso), .dtr_pin_o(dtr)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // one cycle: drive at negedge, sample 1 ns later
  task automatic step(input logic b, input logic p, input logic d,
                      input logic r, input logic s);
    @(negedge clk);
    brg = b; rxp = p; dsr = d; ri = r; start = s;
    #1;
    n_rx += int'(rx_s);
    n_tx += int'(tx_b);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(0, 0, 0, 0, 0);
  endtask

  task automatic write_cfg(input logic [7:0] v);
    @(negedge clk);
    cfg_we = 1'b1; cfg_wdata = v;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic soft_rst();
    @(negedge clk);
    chan_rst = 1'b1;
    @(negedge clk);
    chan_rst = 1'b0;
  endtask

  // kind: 0 rx clk pin, 1 dsr, 2 brg tick, 3 ri
  task automatic stim(input int kind);
    n_rx = 0; n_tx = 0;
    if (kind == 2) begin
      step(1, 0, 0, 0, 0);
      idle(2);
    end else begin
      for (int i = 0; i < 3; i++)
        step(0, kind == 0, kind == 1, kind == 3, 0);
      idle(4);
    end
  endtask

  task automatic t_reset();
    modem = 1'b1;
    idle(2);
    chk("R1 cfg", cfg_rdata, 0);
    chk("R1 rx_iso", rx_iso, 0);
    chk("R1 tx_iso", tx_iso, 0);
    chk("R1 dtr follows modem", dtr, 1);
    modem = 1'b0;
  endtask

  task automatic t_cfg();
    write_cfg(8'hFF);
    idle(1);
    chk("R2 bit2 masked", cfg_rdata, 8'hFB);
    write_cfg(8'h24);
    idle(1);
    chk("R2 store", cfg_rdata, 8'h20);
    write_cfg(8'h00);
  endtask

  task automatic t_sync();
    int seq[5];
    write_cfg(8'h08);
    idle(3);
    for (int i = 0; i < 5; i++) begin
      step(0, 1, 0, 0, 0);
      seq[i] = int'(rx_s);
    end
    chk("R10 no early", seq[0] + seq[1], 0);
    chk("R10 latency", seq[2], 1);
    chk("R10 single while high", seq[3] + seq[4], 0);
    idle(4);
  endtask

  task automatic t_rx_src();
    for (int src = 0; src < 4; src++) begin
      write_cfg(8'h08 | 8'(src));
      idle(4);
      for (int k = 0; k < 4; k++) begin
        int exp;
        stim(k);
        exp = ((src == 0 && k == 0) || (src == 1 && k == 1) ||
               (src >= 2 && k == 2)) ? 1 : 0;
        chk($sformatf("R4 src %0d stim %0d", src, k), n_rx, exp);
      end
    end
    write_cfg(8'h4B);
    idle(4);
    stim(3);
    chk("R4 src 3 follows ri", n_rx, 1);
    stim(2);
    chk("R4 src 3 ignores brg", n_rx, 0);
    chk("R5 rx_iso flag", rx_iso, 1);
  endtask

  task automatic t_tx_src();
    write_cfg(8'h80);
    idle(4);
    chk("R8 tx_iso flag", tx_iso, 1);
    stim(2);
    chk("R7 brg to tx", n_tx, 1);
    stim(3);
    chk("R7 ri ignored", n_tx, 0);
    write_cfg(8'hC0);
    idle(4);
    stim(3);
    chk("R7 ri to tx", n_tx, 1);
    stim(2);
    chk("R7 brg ignored", n_tx, 0);
  endtask

  task automatic t_nx();
    int first, cnt;
    write_cfg(8'h0A);
    n_rx = 0;
    for (int i = 0; i < 3; i++) begin step(1, 0, 0, 0, 0); idle(1); end
    chk("R5 iso every tick", n_rx, 3);
    write_cfg(8'h02);
    soft_rst();
    chk("R6 rx_iso clear", rx_iso, 0);
    first = -1; cnt = 0;
    for (int i = 0; i < 2 * OVS; i++) begin
      step(1, 0, 0, 0, 0);
      if (rx_s) begin cnt++; if (first < 0) first = i; end
      idle(1);
    end
    chk("R6 wrap count", cnt, 2);
    chk("R6 first strobe", first, OVS - 1);
    step(0, 0, 0, 0, 1);
    first = -1;
    for (int i = 0; i < OVS; i++) begin
      step(1, 0, 0, 0, 0);
      if (rx_s && first < 0) first = i;
      idle(1);
    end
    chk("R6 mid-bit realign", first, OVS / 2 - 1);
    write_cfg(8'h00);
    soft_rst();
    n_tx = 0;
    for (int i = 0; i < 2 * OVS; i++) begin step(1, 0, 0, 0, 0); idle(1); end
    chk("R8 tx Nx count", n_tx, 2);
  endtask

  task automatic t_soft();
    int first;
    write_cfg(8'h02);
    soft_rst();
    for (int i = 0; i < 3; i++) begin step(1, 0, 0, 0, 0); idle(1); end
    soft_rst();
    first = -1;
    for (int i = 0; i < OVS; i++) begin
      step(1, 0, 0, 0, 0);
      if (rx_s && first < 0) first = i;
      idle(1);
    end
    chk("R3 prescaler cleared", first, OVS - 1);
    write_cfg(8'h5A);
    soft_rst();
    idle(1);
    chk("R3 cfg kept", cfg_rdata, 8'h5A);
  endtask

  task automatic t_dtr();
    write_cfg(8'h00);
    modem = 1'b1; idle(2);
    chk("R9 mode 0 high", dtr, 1);
    modem = 1'b0; idle(2);
    chk("R9 mode 0 low", dtr, 0);
    write_cfg(8'h30);
    modem = 1'b1; idle(2);
    chk("R9 reserved like 0", dtr, 1);
    write_cfg(8'h20);
    idle(2);
    chk("R9 brg mode ignores modem", dtr, 0);
    step(1, 0, 0, 0, 0);
    chk("R9 brg not yet", dtr, 0);
    idle(1);
    chk("R9 brg delayed", dtr, 1);
    idle(1);
    chk("R9 brg one cycle", dtr, 0);
    write_cfg(8'h90);
    idle(2);
    step(1, 0, 0, 0, 0);
    idle(1);
    chk("R9 tx bit out", dtr, 1);
    idle(1);
    chk("R9 tx bit ends", dtr, 0);
    modem = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    t_reset();
    t_cfg();
    t_sync();
    t_rx_src();
    t_tx_src();
    t_nx();
    t_soft();
    t_dtr();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

endmodule